// File: doc/BRIEF.md
# Serial Converter Host Controller

This block is the host-side master for the serial port of a multi-channel converter whose port is externally clocked. It accepts two kinds of command. A control write shifts a five-bit control word to the converter under a write frame select. A conversion read collects a sixteen-bit frame under a read frame select. The block produces the serial clock from a divider counted in system clocks. Both frame selects and the outgoing data line are generated in step with that clock.

A read frame has a leading marker bit that must be zero, three channel address bits and a twelve-bit result sent MSB first. The block splits the captured frame into those fields and flags a frame error when the marker is one. The result is presented even when the flag is set. A control write always runs six serial clocks, and the padding bit after the five meaningful bits is driven low. One command is handled at a time, and a busy output gates acceptance.

Top module: `adc_serial_host`

## Requirements
- R1: After reset, and whenever `busy_o` is low, `ser_clk_o`, `wsel_no` and `rsel_no` are high, and `busy_o` and both done pulses are low. Directly after reset `ser_dout_o`, `rd_addr_o`, `rd_data_o` and `frame_err_o` are zero.
- R2: A write holds `wsel_no` low for exactly six falling edges of `ser_clk_o`. At those edges `ser_dout_o` carries `wr_word_i[4]`, `[3]`, `[2]`, `[1]`, `[0]` and then 0. Bits 4..2 are the channel address, bit 1 is standby and bit 0 is the conversion start.
- R3: `ser_dout_o` changes only while `ser_clk_o` is high, so it is stable at every falling edge.
- R4: A read holds `rsel_no` low for exactly sixteen falling edges of `ser_clk_o` and samples `ser_din_i` at each of them. Taking the first sampled bit as frame bit 15, `rd_addr_o` becomes bits 14..12 and `rd_data_o` becomes bits 11..0. These values are presented together with a one-cycle `rd_done_o` pulse.
- R5: `frame_err_o` is set to the first sampled bit of a read and is updated only with `rd_done_o`. A set flag does not suppress the address or result.
- R6: Let the half-period be H = max(`div_i`, 1) system clocks, latched at acceptance. A frame select falls on the clock edge that accepts a command, and it falls while `ser_clk_o` is high. The first falling edge comes H cycles later, and the clock toggles every H cycles after that. The select rises H cycles after the last rising edge, on the same edge as the one-cycle done pulse. For N clocks the done pulse comes (2N+1)·H cycles after acceptance.
- R7: `busy_o` is high from the edge that accepts a command until the edge that raises the done pulse. Requests that arrive while `busy_o` is high are dropped, and no frame is started for them.
- R8: When both requests are high on an accepting cycle, the write is started and the read request is dropped.
- R9: `rd_addr_o`, `rd_data_o` and `frame_err_o` hold their values across writes until the next read completes.
- R10: `wsel_no` and `rsel_no` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W | Serial clock half-period in system clocks (0 acts as 1) |
| wr_req_i | input | 1 | Start a control write (taken only when not busy) |
| wr_word_i | input | 5 | Control word: [4:2] address, [1] standby, [0] convert |
| rd_req_i | input | 1 | Start a conversion read (taken only when not busy) |
| busy_o | output | 1 | A frame is in progress |
| ser_clk_o | output | 1 | Serial clock, idles high |
| wsel_no | output | 1 | Write frame select, active low |
| rsel_no | output | 1 | Read frame select, active low |
| ser_dout_o | output | 1 | Serial data to the converter |
| ser_din_i | input | 1 | Serial data from the converter |
| wr_done_o | output | 1 | One-cycle pulse at the end of a write |
| rd_done_o | output | 1 | One-cycle pulse at the end of a read |
| rd_addr_o | output | 3 | Channel address from the last read |
| rd_data_o | output | 12 | Conversion result from the last read |
| frame_err_o | output | 1 | Marker bit of the last read was one |

## Verification
The assertions assume that `ser_din_i` is settled before each serial falling edge. They assume nothing about request timing, because the controller drops requests while busy. The bench's converter model changes `ser_din_i` only at a read-select fall or a serial rising edge, never near a falling edge. Requests are driven on the falling system edge and held for one cycle, and `div_i` is changed only between frames. The busy and priority tests deliberately overlap requests to exercise the drop behaviour.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  localparam int unsigned CTRL_BITS = 5;
  localparam int unsigned WR_CLKS   = 6;
  localparam int unsigned RD_BITS   = 16;
  localparam int unsigned ADDR_W    = 3;
  localparam int unsigned RES_W     = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_TAIL
  } seq_state_e;
endpackage

// File: rtl/adc_half_timer.sv
module adc_half_timer #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last_cnt;

  // zero divider behaves as one
  assign last_cnt = (div_i == '0) ? '0 : div_i - 1'b1;
  assign tick_o   = run_i && (cnt_q == last_cnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (restart_i || tick_o)  cnt_q <= '0;
    else if (run_i)                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_tx_shifter.sv
module adc_tx_shifter #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  output logic         bit_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= load_val_i;
    else if (shift_i) sh_q <= {sh_q[W-2:0], 1'b0};
  end

  assign bit_o = sh_q[W-1];
endmodule

// File: rtl/adc_rx_shifter.sv
module adc_rx_shifter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_o <= '0;
    else if (clr_i)   word_o <= '0;
    else if (shift_i) word_o <= {word_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_host_pkg::*;
#(
  parameter int unsigned WR_N = WR_CLKS,
  parameter int unsigned RD_N = RD_BITS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_req_i,
  input  logic rd_req_i,
  input  logic tick_i,
  output logic accept_o,
  output logic accept_wr_o,
  output logic run_o,
  output logic fall_o,
  output logic shift_o,
  output logic finish_rd_o,
  output logic is_wr_o,
  output logic ser_clk_o,
  output logic wsel_no,
  output logic rsel_no,
  output logic busy_o,
  output logic wr_done_o,
  output logic rd_done_o
);
  localparam int unsigned MAX_N = (RD_N > WR_N) ? RD_N : WR_N;
  localparam int unsigned CNT_W = $clog2(MAX_N + 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] bit_cnt_q;
  logic [CNT_W-1:0] last_bit;
  logic             at_last;

  assign last_bit    = is_wr_o ? CNT_W'(WR_N) : CNT_W'(RD_N);
  assign at_last     = (bit_cnt_q == last_bit);
  assign accept_o    = (state_q == ST_IDLE) && (wr_req_i || rd_req_i);
  assign accept_wr_o = (state_q == ST_IDLE) && wr_req_i;
  assign run_o       = (state_q != ST_IDLE);
  assign busy_o      = run_o;
  assign fall_o      = tick_i && ((state_q == ST_SETUP) || (state_q == ST_HIGH));
  assign shift_o     = tick_i && (state_q == ST_LOW) && !at_last;
  assign finish_rd_o = tick_i && (state_q == ST_TAIL) && !is_wr_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      is_wr_o   <= 1'b0;
      ser_clk_o <= 1'b1;
      wsel_no   <= 1'b1;
      rsel_no   <= 1'b1;
      wr_done_o <= 1'b0;
      rd_done_o <= 1'b0;
    end else begin
      wr_done_o <= 1'b0;
      rd_done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          bit_cnt_q <= '0;
          if (wr_req_i) begin
            // write wins a tie
            wsel_no <= 1'b0;
            is_wr_o <= 1'b1;
            state_q <= ST_SETUP;
          end else if (rd_req_i) begin
            rsel_no <= 1'b0;
            is_wr_o <= 1'b0;
            state_q <= ST_SETUP;
          end
        end
        ST_SETUP, ST_HIGH: begin
          if (tick_i) begin
            ser_clk_o <= 1'b0;
            bit_cnt_q <= bit_cnt_q + 1'b1;
            state_q   <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (tick_i) begin
            ser_clk_o <= 1'b1;
            state_q   <= at_last ? ST_TAIL : ST_HIGH;
          end
        end
        ST_TAIL: begin
          if (tick_i) begin
            wsel_no   <= 1'b1;
            rsel_no   <= 1'b1;
            wr_done_o <= is_wr_o;
            rd_done_o <= !is_wr_o;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_serial_host.sv
module adc_serial_host
  import adc_host_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              wr_req_i,
  input  logic [CTRL_BITS-1:0] wr_word_i,
  input  logic              rd_req_i,
  output logic              busy_o,
  output logic              ser_clk_o,
  output logic              wsel_no,
  output logic              rsel_no,
  output logic              ser_dout_o,
  input  logic              ser_din_i,
  output logic              wr_done_o,
  output logic              rd_done_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [RES_W-1:0]  rd_data_o,
  output logic              frame_err_o
);
  localparam int unsigned TX_PAD = WR_CLKS - CTRL_BITS;

  logic             accept, accept_wr, run, fall, shift, finish_rd, is_wr, tick;
  logic [DIV_W-1:0] div_q;
  logic [WR_CLKS-1:0] tx_load;
  logic [RD_BITS-1:0] rx_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (accept) div_q <= div_i;
  end

  assign tx_load = accept_wr ? {wr_word_i, {TX_PAD{1'b0}}} : '0;

  adc_seq_ctrl #(.WR_N(WR_CLKS), .RD_N(RD_BITS)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_req_i    (wr_req_i),
    .rd_req_i    (rd_req_i),
    .tick_i      (tick),
    .accept_o    (accept),
    .accept_wr_o (accept_wr),
    .run_o       (run),
    .fall_o      (fall),
    .shift_o     (shift),
    .finish_rd_o (finish_rd),
    .is_wr_o     (is_wr),
    .ser_clk_o   (ser_clk_o),
    .wsel_no     (wsel_no),
    .rsel_no     (rsel_no),
    .busy_o      (busy_o),
    .wr_done_o   (wr_done_o),
    .rd_done_o   (rd_done_o)
  );

  adc_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (accept),
    .run_i     (run),
    .div_i     (div_q),
    .tick_o    (tick)
  );

  adc_tx_shifter #(.W(WR_CLKS)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_val_i (tx_load),
    .shift_i    (shift),
    .bit_o      (ser_dout_o)
  );

  adc_rx_shifter #(.W(RD_BITS)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (accept),
    .shift_i (fall && !is_wr),
    .bit_i   (ser_din_i),
    .word_o  (rx_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_addr_o   <= '0;
      rd_data_o   <= '0;
      frame_err_o <= 1'b0;
    end else if (finish_rd) begin
      frame_err_o <= rx_word[RD_BITS-1];
      rd_addr_o   <= rx_word[RES_W +: ADDR_W];
      rd_data_o   <= rx_word[RES_W-1:0];
    end
  end
endmodule

// File: rtl/adc_serial_host_chk.sv
module adc_serial_host_chk
  import adc_host_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic ser_clk_o,
  input logic wsel_no,
  input logic rsel_no,
  input logic ser_dout_o,
  input logic wr_done_o,
  input logic rd_done_o,
  input logic frame_err_o
);
  localparam int unsigned FC_W = $clog2(RD_BITS + 1) + 1;

  logic            clk_q;
  logic [FC_W-1:0] fall_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_q    <= 1'b1;
      fall_cnt <= '0;
    end else begin
      clk_q <= ser_clk_o;
      if (wsel_no && rsel_no)     fall_cnt <= '0;
      else if (clk_q && !ser_clk_o) fall_cnt <= fall_cnt + 1'b1;
    end
  end

  assert_idle_lines_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ser_clk_o && wsel_no && rsel_no));
  assert_wr_fall_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done_o |-> (fall_cnt == FC_W'(WR_CLKS)));
  assert_dout_moves_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ser_dout_o) |-> ser_clk_o);
  assert_rd_fall_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_o |-> (fall_cnt == FC_W'(RD_BITS)));
  assert_err_only_on_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(frame_err_o) |-> rd_done_o);
  assert_sel_fall_clk_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(wsel_no) || $fell(rsel_no)) |-> ser_clk_o);
  assert_rd_done_at_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_o |-> (rsel_no && $past(!rsel_no)));
  assert_wr_done_at_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done_o |-> (wsel_no && $past(!wsel_no)));
  assert_clk_moves_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ser_clk_o) |-> busy_o);
  assert_select_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wsel_no || !rsel_no) |-> busy_o);
  assert_one_select_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wsel_no |-> rsel_no);
endmodule

bind adc_serial_host adc_serial_host_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .ser_clk_o   (ser_clk_o),
  .wsel_no     (wsel_no),
  .rsel_no     (rsel_no),
  .ser_dout_o  (ser_dout_o),
  .wr_done_o   (wr_done_o),
  .rd_done_o   (rd_done_o),
  .frame_err_o (frame_err_o)
);

// File: tb/adc_serial_host_bench.sv
`timescale 1ns/1ps
module adc_serial_host_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  div = '0;
  logic        wr_req = 1'b0, rd_req = 1'b0;
  logic [4:0]  wr_word = '0;
  logic        busy, sclk, wsel_n, rsel_n, dout, din, wr_done, rd_done, ferr;
  logic [2:0]  raddr;
  logic [11:0] rdata;

  int n_checks = 0, n_fail = 0;
  logic [15:0] frame = '0;
  int wr_falls, rd_falls, wsel_falls, rsel_falls, dout_bad, setup_bad;
  logic [5:0] wr_bits;
  int cyc;
  bit saw_wr, saw_rd, busy_mid;

  always #10 clk = ~clk;

  adc_serial_host u_adc_serial_host (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .wr_req_i(wr_req),
    .wr_word_i(wr_word), .rd_req_i(rd_req), .busy_o(busy),
    .ser_clk_o(sclk), .wsel_no(wsel_n), .rsel_no(rsel_n),
    .ser_dout_o(dout), .ser_din_i(din), .wr_done_o(wr_done),
    .rd_done_o(rd_done), .rd_addr_o(raddr), .rd_data_o(rdata),
    .frame_err_o(ferr)
  );

  // converter model: next bit at select fall and at each rising edge
  initial begin
    din = 1'b0;
    forever begin
      @(negedge rsel_n);
      din = frame[15];
      for (int i = 14; i >= -1; i--) begin
        @(posedge sclk or posedge rsel_n);
        if (rsel_n) break;
        din = (i >= 0) ? frame[i] : 1'b0;
      end
      din = 1'b0;
    end
  end

  initial forever begin
    @(negedge sclk);
    if (!wsel_n) begin wr_bits = {wr_bits[4:0], dout}; wr_falls++; end
    if (!rsel_n) rd_falls++;
  end
  initial forever begin @(negedge wsel_n); wsel_falls++; if (!sclk) setup_bad++; end
  initial forever begin @(negedge rsel_n); rsel_falls++; if (!sclk) setup_bad++; end
  initial forever begin @(dout); if (!sclk) dout_bad++; end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    wr_falls = 0; rd_falls = 0; wsel_falls = 0; rsel_falls = 0;
    dout_bad = 0; setup_bad = 0; wr_bits = '0;
  endtask

  // issue requests, then wait for a done pulse; optional overlap injection
  task automatic transact(input bit w, input bit r, input logic [4:0] word,
                          input logic [7:0] d, input int inject_n);
    clear_mon();
    saw_wr = 0; saw_rd = 0; busy_mid = 0; cyc = 0;
    @(negedge clk);
    div = d; wr_word = word; wr_req = w; rd_req = r;
    forever begin
      @(negedge clk);
      cyc++;
      wr_req = 0; rd_req = 0;
      if (cyc == inject_n) begin wr_req = 1; rd_req = 1; wr_word = 5'h1F; end
      if (cyc == 3) busy_mid = busy;
      if (wr_done) saw_wr = 1;
      if (rd_done) saw_rd = 1;
      if (saw_wr || saw_rd || cyc > 5000) break;
    end
  endtask

  task automatic t_reset();
    check(sclk && wsel_n && rsel_n, "R1", "idle lines", {sclk, wsel_n, rsel_n}, 3'b111);
    check(!busy && !wr_done && !rd_done, "R1", "busy/done", {busy, wr_done, rd_done}, 0);
    check(!dout && raddr == 0 && rdata == 0 && !ferr, "R1", "outputs", {dout, raddr, rdata, ferr}, 0);
  endtask

  task automatic t_write(input logic [4:0] word, input logic [7:0] d);
    int h = (d == 0) ? 1 : d;
    transact(1, 0, word, d, -1);
    check(saw_wr && !saw_rd, "R6", "write done pulse", {saw_wr, saw_rd}, 2'b10);
    check(wr_falls == 6, "R2", "write falls", wr_falls, 6);
    check(wr_bits == {word, 1'b0}, "R2", "write bits", wr_bits, {word, 1'b0});
    check(dout_bad == 0, "R3", "dout change while low", dout_bad, 0);
    check(setup_bad == 0, "R6", "select fell with clock low", setup_bad, 0);
    check(cyc == 13 * h + 1, "R6", "write length", cyc, 13 * h + 1);
    check(busy_mid && !busy && wsel_n, "R7", "busy span", {busy_mid, busy, wsel_n}, 3'b101);
  endtask

  task automatic t_read(input logic [15:0] f, input logic [7:0] d, input int inject_n);
    int h = (d == 0) ? 1 : d;
    frame = f;
    transact(0, 1, 5'h00, d, inject_n);
    check(saw_rd && !saw_wr, "R4", "read done pulse", {saw_rd, saw_wr}, 2'b10);
    check(rd_falls == 16, "R4", "read falls", rd_falls, 16);
    check(raddr == f[14:12], "R4", "address", raddr, f[14:12]);
    check(rdata == f[11:0], "R4", "result", rdata, f[11:0]);
    check(ferr == f[15], "R5", "frame error", ferr, f[15]);
    check(cyc == 33 * h + 1, "R6", "read length", cyc, 33 * h + 1);
    check(setup_bad == 0 && rsel_n && !busy, "R6", "read end state", {setup_bad, rsel_n, busy}, 3'b010);
  endtask

  task automatic t_busy_drop();
    t_read(16'h4C3E, 8'd2, 10);
    check(wsel_falls == 0, "R7", "write select during busy read", wsel_falls, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(wsel_n && rsel_n && !busy && !wr_done, "R7", "dropped request started",
            {wsel_n, rsel_n, busy, wr_done}, 4'b1100);
    end
  endtask

  task automatic t_priority_and_hold();
    logic [2:0]  a0 = raddr;
    logic [11:0] d0 = rdata;
    logic        e0 = ferr;
    transact(1, 1, 5'b11001, 8'd1, -1);
    check(saw_wr && !saw_rd && rsel_falls == 0, "R8", "write wins tie",
          {saw_wr, saw_rd, rsel_falls[0]}, 3'b100);
    check(wr_bits == 6'b110010, "R8", "write bits on tie", wr_bits, 6'b110010);
    check(raddr == a0 && rdata == d0 && ferr == e0, "R9", "read outputs held",
          {raddr, rdata, ferr}, {a0, d0, e0});
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write(5'b10110, 8'd2);
    t_write(5'b01001, 8'd0);
    t_read(16'h5ABC, 8'd1, -1);
    t_read(16'h35A3, 8'd3, -1);
    t_read(16'hEF0F, 8'd2, -1);  // marker set: R5
    t_busy_drop();               // also clears the error flag
    t_priority_and_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule